// File: doc/BRIEF.md
# Masked Packed-Lane Reciprocal Writeback

This block takes a packed vector of single-precision lanes, runs each selected lane through a per-lane reciprocal slot, and writes the results back into a destination vector under a lane mask. The destination is built from three kinds of lane. A selected lane receives the slot result. A masked-off lane inside the active length either keeps its old destination value or is cleared. Every lane beyond the active vector length is cleared.

The caller provides the source vector, the old destination contents, a lane mask with its enable, a zeroing-mode bit, a broadcast request, a flag marking the source as coming from memory, and a length code. A broadcast takes effect only for a memory source. In that case every lane reads source element 0.

The lane slot here is a fixed-latency stand-in estimator, exact for powers of two. It can be swapped for a higher-precision unit without changing the writeback logic. Results appear a fixed number of cycles after the request, together with a one-cycle valid pulse.

Top module: `masked_lane_wb`

## Requirements
- R1: The length code `vl_sel` sets the active lane count: 0 gives LANES/4 (4 by default), 1 gives LANES/2 (8), and 2 or 3 give LANES (16). Lane j occupies bits [32j+31:32j].
- R2: An active lane j takes the slot result when `mask_en` is low, or when `lane_mask[j]` is 1.
- R3: When `bcast` and `src_is_mem` are both 1, every written lane takes the slot result of source element 0.
- R4: When `bcast` is 1 and `src_is_mem` is 0, the broadcast request has no effect, and lane j takes the result of source element j.
- R5: An active lane that is masked off (`mask_en`=1, mask bit 0) keeps its `old_dst` value when `zero_mode` is 0.
- R6: An active lane that is masked off is written as 32'h0 when `zero_mode` is 1.
- R7: Every bit of `dst_out` at or above 32 × (active lane count) is 0 after a result, whatever the old destination holds.
- R8: Mask bits at positions at or above the active lane count have no effect on the result.
- R9: A request sampled with `in_valid` at rising edge k makes `out_valid` high for exactly one cycle, after edge k+LAT. `dst_out` holds its value whenever `out_valid` is low.
- R10: The slot maps input {s,e,m} as follows. e=0 gives {s,8'hFF,23'h0}. e=255 with m≠0 gives the input with bit 22 set. e=255 with m=0 gives {s,31'h0}. e=254 gives {s,31'h0}. Any other e gives {s,254−e,23'h0}; the mantissa is ignored.
- R11: While reset is held and after its release, `out_valid` is 0 and `dst_out` is all zeros until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Packed source lanes |
| old_dst | input | 512 | Prior destination contents |
| lane_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Apply lane_mask when 1 |
| zero_mode | input | 1 | Clear masked-off lanes when 1, keep them when 0 |
| bcast | input | 1 | Broadcast element 0 request |
| src_is_mem | input | 1 | Source comes from memory |
| vl_sel | input | 2 | Active length code |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 512 | Updated destination vector |

## Verification
The hardest case to reach is a lane that has a mask bit set but lies beyond the active length, while the old destination holds nonzero data there. Only that case shows whether length clearing wins over both the mask and merging. The bench fills `old_dst` with random nonzero words and draws random full-width masks. It sweeps every combination of length code, mask enable, zeroing mode, broadcast and memory flag, so such lanes appear in every configuration. Source lanes are also mixed with zero, all-ones, and near-maximum exponents, so the slot's corner encodings pass through both the broadcast path and the per-lane path.

// File: rtl/mlw_pkg.sv
package mlw_pkg;

    localparam int FP_W = 32;

    typedef enum logic [1:0] {
        VL_QUARTER = 2'd0,
        VL_HALF    = 2'd1,
        VL_FULL    = 2'd2,
        VL_FULL_X  = 2'd3
    } vlen_e;

    // Stand-in reciprocal estimate: reflects the exponent, drops the mantissa.
    function automatic logic [FP_W-1:0] recip_est(input logic [FP_W-1:0] x);
        logic       s;
        logic [7:0] e;
        logic [22:0] m;
        s = x[31];
        e = x[30:23];
        m = x[22:0];
        if (e == 8'd0)
            recip_est = {s, 8'hFF, 23'h0};
        else if (e == 8'hFF)
            recip_est = (m != 23'h0) ? (x | 32'h0040_0000) : {s, 31'h0};
        else if (e == 8'd254)
            recip_est = {s, 31'h0};
        else
            recip_est = {s, 8'(8'd254 - e), 23'h0};
    endfunction

endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= din;
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/lane_slot.sv
module lane_slot
    import mlw_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FP_W-1:0] din,
    output logic [FP_W-1:0] dout
);
    logic [FP_W-1:0] est;

    always_comb est = recip_est(din);

    pipe_delay #(.W(FP_W), .DEPTH(LAT)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (est),
        .dout (dout)
    );
endmodule

// File: rtl/lane_src_sel.sv
module lane_src_sel
    import mlw_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES*FP_W-1:0] src_vec,
    input  logic                  bcast_en,
    output logic [LANES*FP_W-1:0] sel_vec
);
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign sel_vec[j*FP_W +: FP_W] = bcast_en ? src_vec[FP_W-1:0]
                                                      : src_vec[j*FP_W +: FP_W];
        end
    endgenerate
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import mlw_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0]      wr,
    input  logic [LANES-1:0]      keep,
    input  logic [LANES*FP_W-1:0] res_vec,
    input  logic [LANES*FP_W-1:0] old_vec,
    output logic [LANES*FP_W-1:0] merged
);
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            always_comb begin
                unique case ({wr[j], keep[j]})
                    2'b10, 2'b11: merged[j*FP_W +: FP_W] = res_vec[j*FP_W +: FP_W];
                    2'b01:        merged[j*FP_W +: FP_W] = old_vec[j*FP_W +: FP_W];
                    default:      merged[j*FP_W +: FP_W] = '0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/masked_lane_wb.sv
module masked_lane_wb
    import mlw_pkg::*;
#(
    parameter int LANES = 16,
    parameter int LAT   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*FP_W-1:0] src_vec,
    input  logic [LANES*FP_W-1:0] old_dst,
    input  logic [LANES-1:0]      lane_mask,
    input  logic                  mask_en,
    input  logic                  zero_mode,
    input  logic                  bcast,
    input  logic                  src_is_mem,
    input  logic [1:0]            vl_sel,
    output logic                  out_valid,
    output logic [LANES*FP_W-1:0] dst_out
);
    localparam int DW = LANES * FP_W;
    localparam int CW = $clog2(LANES) + 1;
    localparam int SW = 1 + 2 * LANES + DW + 2;

    vlen_e            vl_in;
    vlen_e            vl_d;
    vlen_e            vl_q;
    logic [CW-1:0]    n_act;
    logic [LANES-1:0] wr_in, keep_in, wr_d, keep_d;
    logic [DW-1:0]    sel_vec, res_vec, old_d, merged;
    logic             v_d;
    logic [1:0]       vl_bits_d;

    assign vl_in = vlen_e'(vl_sel);

    always_comb begin
        unique case (vl_in)
            VL_QUARTER: n_act = CW'(LANES / 4);
            VL_HALF:    n_act = CW'(LANES / 2);
            VL_FULL:    n_act = CW'(LANES);
            VL_FULL_X:  n_act = CW'(LANES);
            default:    n_act = CW'(LANES);
        endcase
    end

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_ctl
            logic act;
            assign act        = (CW'(j) < n_act);
            assign wr_in[j]   = act & (lane_mask[j] | ~mask_en);
            assign keep_in[j] = act & ~(lane_mask[j] | ~mask_en) & ~zero_mode;
        end
    endgenerate

    lane_src_sel #(.LANES(LANES)) u_sel (
        .src_vec (src_vec),
        .bcast_en(bcast & src_is_mem),
        .sel_vec (sel_vec)
    );

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_slot
            lane_slot #(.LAT(LAT)) u_slot (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (sel_vec[j*FP_W +: FP_W]),
                .dout (res_vec[j*FP_W +: FP_W])
            );
        end
    endgenerate

    pipe_delay #(.W(SW), .DEPTH(LAT)) u_side (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({in_valid, wr_in, keep_in, old_dst, vl_sel}),
        .dout ({v_d, wr_d, keep_d, old_d, vl_bits_d})
    );

    assign vl_d = vlen_e'(vl_bits_d);

    lane_merge #(.LANES(LANES)) u_merge (
        .wr     (wr_d),
        .keep   (keep_d),
        .res_vec(res_vec),
        .old_vec(old_d),
        .merged (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
            vl_q      <= VL_FULL;
        end else begin
            out_valid <= v_d;
            if (v_d) begin
                dst_out <= merged;
                vl_q    <= vl_d;
            end
        end
    end
endmodule

// File: rtl/masked_lane_wb_chk.sv
module masked_lane_wb_chk #(
    parameter int LANES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic                  bcast,
    input logic                  src_is_mem,
    input logic [LANES*32-1:0]   src_vec,
    input logic [LANES*32-1:0]   sel_vec,
    input logic [LANES*32-1:0]   dst_out,
    input logic [1:0]            vl_q
);
    localparam int DW = LANES * 32;
    localparam int TOP = (LANES - 1) * 32;

    int unsigned pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 0;
        else        pend <= pend + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
    end

    p_bcast_elem0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast && src_is_mem) |-> sel_vec[TOP +: 32] == src_vec[31:0]);

    p_reg_src_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bcast && src_is_mem) |-> sel_vec[TOP +: 32] == src_vec[TOP +: 32]);

    p_quarter_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vl_q == 2'd0) |-> dst_out[DW-1:DW/4] == '0);

    p_half_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vl_q == 2'd1) |-> dst_out[DW-1:DW/2] == '0);

    p_no_orphan_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pend != 0);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> $stable(dst_out) || out_valid);
endmodule

bind masked_lane_wb masked_lane_wb_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .bcast     (bcast),
    .src_is_mem(src_is_mem),
    .src_vec   (src_vec),
    .sel_vec   (sel_vec),
    .dst_out   (dst_out),
    .vl_q      (vl_q)
);

// File: tb/masked_lane_wb_tb.sv
module masked_lane_wb_tb;
    localparam int LANES = 16;
    localparam int LAT   = 2;
    localparam int DW    = LANES * 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    src_vec = '0;
    logic [DW-1:0]    old_dst = '0;
    logic [LANES-1:0] lane_mask = '0;
    logic             mask_en = 1'b0;
    logic             zero_mode = 1'b0;
    logic             bcast = 1'b0;
    logic             src_is_mem = 1'b0;
    logic [1:0]       vl_sel = 2'd0;
    logic             out_valid;
    logic [DW-1:0]    dst_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    masked_lane_wb #(.LANES(LANES), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast(bcast), .src_is_mem(src_is_mem),
        .vl_sel(vl_sel), .out_valid(out_valid), .dst_out(dst_out)
    );

    function automatic logic [31:0] ref_recip(input logic [31:0] x);
        logic [7:0] e;
        e = x[30:23];
        if (e == 0)                 return {x[31], 8'hFF, 23'h0};
        if (e == 255 && x[22:0] != 0) return x | 32'h0040_0000;
        if (e >= 254)               return {x[31], 31'h0};
        return {x[31], 8'(254 - e), 23'h0};
    endfunction

    function automatic int lanes_of(input logic [1:0] v);
        return (v == 0) ? LANES / 4 : (v == 1) ? LANES / 2 : LANES;
    endfunction

    function automatic logic [31:0] rand_fp();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 6)
            0: r[30:23] = 8'd0;
            1: r[30:23] = 8'hFF;
            2: r[30:23] = 8'd254;
            3: r[30:23] = 8'd127;
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] v, input bit me, input bit zm, input bit bc, input bit mm);
        logic [DW-1:0] exp_vec;
        int n;
        int nl;
        nl = lanes_of(v);
        @(negedge clk);
        for (int j = 0; j < LANES; j++) begin
            src_vec[j*32 +: 32] = rand_fp();
            old_dst[j*32 +: 32] = $urandom | 32'h1;
        end
        lane_mask = LANES'($urandom);
        vl_sel = v; mask_en = me; zero_mode = zm; bcast = bc; src_is_mem = mm;
        in_valid = 1'b1;
        for (int j = 0; j < LANES; j++) begin
            if (j >= nl)
                exp_vec[j*32 +: 32] = '0;
            else if (!me || lane_mask[j])
                exp_vec[j*32 +: 32] = ref_recip(src_vec[((bc && mm) ? 0 : j)*32 +: 32]);
            else
                exp_vec[j*32 +: 32] = zm ? 32'h0 : old_dst[j*32 +: 32];
        end
        n = 0;
        while (n < 20) begin
            @(posedge clk); #1;
            n++;
            in_valid = 1'b0;
            if (out_valid) break;
        end
        check(n == LAT + 1, "R9 latency", 32'(n), 32'(LAT + 1));
        for (int j = 0; j < LANES; j++) begin
            string tag;
            if (j >= nl)                 tag = "R1 R7 R8 beyond length";
            else if (!me)                tag = (bc && mm) ? "R2 R3 unmasked" : "R2 R4 R10 unmasked";
            else if (lane_mask[j])       tag = (bc && mm) ? "R3 masked-in" : "R4 R10 masked-in";
            else                         tag = zm ? "R6 zeroing" : "R5 merging";
            check(dst_out[j*32 +: 32] === exp_vec[j*32 +: 32], tag,
                  dst_out[j*32 +: 32], exp_vec[j*32 +: 32]);
        end
        @(posedge clk); #1;
        check(!out_valid, "R9 single pulse", 32'(out_valid), 32'h0);
        check(dst_out === exp_vec, "R9 hold", dst_out[31:0], exp_vec[31:0]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid, "R11 reset valid", 32'(out_valid), 32'h0);
        check(dst_out === '0, "R11 reset data", dst_out[31:0], 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!out_valid && dst_out === '0, "R11 after release", dst_out[31:0], 32'h0);
        for (int v = 0; v < 4; v++)
            for (int me = 0; me < 2; me++)
                for (int zm = 0; zm < 2; zm++)
                    for (int bc = 0; bc < 2; bc++)
                        for (int mm = 0; mm < 2; mm++)
                            for (int rep = 0; rep < 4; rep++)
                                run_op(2'(v), me[0], zm[0], bc[0], mm[0]);
        done = 1;
        finish_run();
    end
endmodule